// File: doc/BRIEF.md
# Interrupt Enable and Fast/Normal Steering Front End

This block is the register-mapped front end of a 32-source interrupt controller. It takes 32 level-sensitive request lines and masks each one with a per-source enable bit. Each enabled request then goes to one of two CPU lines: the fast interrupt line (FIQ) or the normal interrupt line (IRQ). A per-source type-select bit picks the line.

Software reaches the block over a simple synchronous register bus. The bus carries a byte address, a write strobe, write data and combinational read data. The enable register is set-only: writing 1 enables a source, and writing 0 leaves the source alone. A separate write-only clear register disables sources. Three read-only status words return the steered normal vector, the steered fast vector and the raw request vector. Both CPU lines are registered.

Top module: `irq_steer`

## Requirements
- R1: After reset, every enable bit and every type-select bit is 0, and both `fiq_o` and `irq_o` are 0.
- R2: The type-select word at byte offset 0x0C is fully readable and writable. A bit of 1 sends that source to FIQ, and a bit of 0 sends it to IRQ.
- R3: A write to the enable word at offset 0x10 sets every enable bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A read of offset 0x10 returns the current enable vector, where 1 means the source may reach the CPU.
- R5: A write to offset 0x14 clears every enable bit written as 1 and ignores bits written as 0. A read of 0x14 returns zero.
- R6: `fiq_o` equals the OR over all sources of request AND enable AND select, as the inputs and registers stood one clock earlier.
- R7: `irq_o` equals the OR over all sources of request AND enable AND NOT select, as the inputs and registers stood one clock earlier.
- R8: Offsets 0x00, 0x04 and 0x08 read, in the same cycle, the steered IRQ vector, the steered FIQ vector and the raw request vector.
- R9: Address bits [1:0] are ignored. Reads of any other offset return zero. Writes to read-only or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Level-sensitive request lines, one per source |
| bus_addr | input | AW | Register byte address |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Combinational read data for `bus_addr` |
| fiq_o | output | 1 | Registered fast interrupt line |
| irq_o | output | 1 | Registered normal interrupt line |

## Verification
The steering function is tried three ways:
- A single source is enabled and toggled between the two lines. This separates a select bit that is inverted from a select bit that is ignored.
- Requests are raised while their enables are still off. This shows whether the mask is applied at all.
- Long random mixes of requests, select values and set/clear writes are run. These catch OR-reduction or one-cycle timing slips that appear only when several sources are active on both lines at once.

Directed writes of zeros to the set and clear words, and writes to the status offsets, separate a correct set-only or clear-only update from a plain overwrite.

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            fiq_o,
  output logic            irq_o
);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_IRQST = WW'(0);
  localparam logic [WW-1:0] W_FIQST = WW'(1);
  localparam logic [WW-1:0] W_RAW   = WW'(2);
  localparam logic [WW-1:0] W_SEL   = WW'(3);
  localparam logic [WW-1:0] W_ENSET = WW'(4);
  localparam logic [WW-1:0] W_ENCLR = WW'(5);

  logic [WW-1:0]   word;
  logic [NSRC-1:0] sel_q, en_q, set_m, clr_m, hit_fiq, hit_irq;

  assign word    = bus_addr[AW-1:2];
  assign set_m   = (bus_wr && word == W_ENSET) ? bus_wdata : '0;
  assign clr_m   = (bus_wr && word == W_ENCLR) ? bus_wdata : '0;
  assign hit_fiq = irq_req & en_q & sel_q;
  assign hit_irq = irq_req & en_q & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (bus_wr && word == W_SEL) sel_q <= bus_wdata;
      en_q  <= (en_q | set_m) & ~clr_m;
      fiq_o <= |hit_fiq;
      irq_o <= |hit_irq;
    end
  end

  always_comb begin
    case (word)
      W_IRQST: bus_rdata = hit_irq;
      W_FIQST: bus_rdata = hit_fiq;
      W_RAW:   bus_rdata = irq_req;
      W_SEL:   bus_rdata = sel_q;
      W_ENSET: bus_rdata = en_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_req,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] bus_rdata,
  input logic            fiq_o,
  input logic            irq_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] sel_q
);
  logic [AW-3:0] word;
  assign word = bus_addr[AW-1:2];

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && sel_q == '0 && !fiq_o && !irq_o));

  a_r3_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == (AW-2)'(4)) |=> ((en_q & $past(en_q)) == $past(en_q)));

  a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == (AW-2)'(5)) |=> ((en_q & $past(bus_wdata)) == '0));

  a_r5_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word == (AW-2)'(5)) |-> (bus_rdata == '0));

  a_r6_fiq_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == $past(|(irq_req & en_q & sel_q))));

  a_r7_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(irq_req & en_q & ~sel_q))));

  a_r9_ro_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word < (AW-2)'(3)) |=> ($stable(en_q) && $stable(sel_q)));
endmodule

bind irq_steer irq_steer_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .fiq_o(fiq_o), .irq_o(irq_o), .en_q(en_q), .sel_q(sel_q)
);

// File: tb/tb_irq_steer.sv
`timescale 1ns/100ps
module tb_irq_steer;
  localparam int NSRC = 32;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic [NSRC-1:0] bus_rdata;
  logic            fiq_o, irq_o;

  int checks = 0;
  int errs   = 0;
  logic [NSRC-1:0] m_en = '0, m_sel = '0;

  always #2.5 clk = ~clk;

  irq_steer #(.NSRC(NSRC), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [NSRC-1:0] act, logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NSRC-1:0] exp_rd(logic [AW-1:0] a, logic [NSRC-1:0] rq);
    case (a[AW-1:2])
      0: return rq & m_en & ~m_sel;
      1: return rq & m_en & m_sel;
      2: return rq;
      3: return m_sel;
      4: return m_en;
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(logic [AW-1:0] a);
    case (a[AW-1:2])
      0, 1, 2: return "R8 status read";
      3: return "R2 select read";
      4: return "R4 enable read";
      5: return "R5 clear reads zero";
      default: return "R9 unmapped read";
    endcase
  endfunction

  // one bus cycle: called and returns at a falling edge
  task automatic step(logic [NSRC-1:0] rq, logic [AW-1:0] a, logic w, logic [NSRC-1:0] d);
    logic ef, ei;
    irq_req = rq; bus_addr = a; bus_wr = w; bus_wdata = d;
    #1;
    chk(rd_tag(a), bus_rdata, exp_rd(a, rq));
    ef = |(rq & m_en & m_sel);
    ei = |(rq & m_en & ~m_sel);
    if (w) begin
      case (a[AW-1:2])
        3: m_sel = d;
        4: m_en = m_en | d;
        5: m_en = m_en & ~d;
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R6 fiq line", NSRC'(fiq_o), NSRC'(ef));
    chk("R7 irq line", NSRC'(irq_o), NSRC'(ei));
  endtask

  initial begin
    #(5.0 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE11));
    repeat (3) @(negedge clk);
    bus_addr = 8'h10; #1; chk("R1 enable reset", bus_rdata, '0);
    bus_addr = 8'h0C; #1; chk("R1 select reset", bus_rdata, '0);
    chk("R1 lines reset", NSRC'({fiq_o, irq_o}), '0);
    @(negedge clk); rst_n = 1'b1;

    // R1: requests with nothing enabled reach neither line
    step('1, 8'h00, 1'b0, '0);
    step('1, 8'h04, 1'b0, '0);
    // R3: set bit 3, then zero writes must not clear it
    step(32'h8, 8'h10, 1'b1, 32'h8);
    step(32'h8, 8'h10, 1'b1, 32'h0);
    step(32'h8, 8'h10, 1'b0, '0);
    // R2: move source 3 to fast line and back
    step(32'h8, 8'h0C, 1'b1, 32'h8);
    step(32'h8, 8'h04, 1'b0, '0);
    step(32'h8, 8'h0C, 1'b1, 32'h0);
    step(32'h8, 8'h00, 1'b0, '0);
    // R5: clear with zero ignored, then clear bit 3; read clear word
    step(32'h8, 8'h14, 1'b1, 32'h0);
    step(32'h8, 8'h14, 1'b1, 32'h8);
    step(32'h8, 8'h14, 1'b0, '0);
    // R9: writes to status and unmapped words leave state alone; low bits ignored
    step('1, 8'h10, 1'b1, 32'hFFFF_0000);
    step('1, 8'h00, 1'b1, 32'hFFFF_FFFF);
    step('1, 8'h08, 1'b1, 32'hFFFF_FFFF);
    step('1, 8'h20, 1'b1, 32'hFFFF_FFFF);
    step('1, 8'h13, 1'b0, '0);
    step('1, 8'h0E, 1'b1, 32'hF0F0_0000);
    step('1, 8'hFC, 1'b0, '0);
    // all sources on the fast line, then the edge source 31 only
    step('1, 8'h10, 1'b1, '1);
    step('1, 8'h0C, 1'b1, '1);
    step(32'h8000_0000, 8'h04, 1'b0, '0);
    step(32'h0000_0001, 8'h14, 1'b1, 32'h7FFF_FFFF);
    step(32'h0000_0001, 8'h10, 1'b0, '0);

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [NSRC-1:0] rq;
      a = AW'({$urandom_range(0, 9), 2'($urandom)});
      rq = $urandom & $urandom;
      step(rq, a, 1'($urandom), $urandom);
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule